// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control of a successive-approximation converter. Two active-low controls, a chip select and a read/convert line, are merged by an OR. A conversion is requested when that merged level falls, which happens on the falling edge of whichever control goes low second. The sequencer then drops `busy` and tests one bit per clock, starting with the most significant. Each trial word goes out on `dac_trial`, and the comparator answer comes back on `cmp_le`. After a fixed number of settle cycles, the finished code is copied into the result register and `busy` returns high. Acquisition of the next sample begins at that point.

A power-down input blocks new starts and abandons any conversion in progress. In both cases the stored result is left untouched. The first conversion completed after reset is marked not valid through `result_ok`. The result is a plain holding register with no handshake, so a reader samples it whenever `busy` is high. Conversion length is `WIDTH + SETTLE_CYC` clocks, and `SETTLE_CYC` must be at least 1.

Top module: `sar_start_seq`

## Requirements
- R1: A conversion starts only on a clock where the OR of `cs_n` and `rdconv_n` is seen low after having been seen high. Either control may fall second, or both may fall together. Keeping both low starts nothing further.
- R2: `busy` goes low on the clock edge that samples the start. It stays low for exactly `WIDTH + SETTLE_CYC` clock cycles and then returns high.
- R3: `result` changes only on the edge at which `busy` returns high after a completed conversion.
- R4: The first trial word after a start has only bit `WIDTH-1` set. Each trial keeps its bit when `cmp_le` is 1 (DAC level at or below the input) and clears it otherwise. With `cmp_le = (dac_trial <= target)`, the result therefore equals `target`. The code is unsigned straight binary.
- R5: A start condition that occurs while `busy` is low is discarded and is not replayed afterwards.
- R6: While `pwr_down` is high, start conditions are ignored. If a conversion is running, it is abandoned: `busy` is high one cycle later. In both cases `result` keeps its value. A start condition seen during power-down is not remembered.
- R7: The first conversion completed after reset latches `result_ok = 0`. Every later completed conversion latches `result_ok = 1`. An abandoned conversion does not count.
- R8: After reset, `busy = 1`, `result = 0`, `result_ok = 0` and `dac_trial = 0`.
- R9: `dac_trial` is 0 whenever `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cs_n | input | 1 | Active-low chip select |
| rdconv_n | input | 1 | Read/convert control, active-low convert |
| pwr_down | input | 1 | High blocks and abandons conversions |
| cmp_le | input | 1 | Comparator: 1 when DAC level is at or below the input |
| busy | output | 1 | Low while converting |
| dac_trial | output | WIDTH | Current trial code driven to the capacitor DAC |
| result | output | WIDTH | Latched conversion result |
| result_ok | output | 1 | 0 for the first completed conversion after reset |

## Verification
The bench builds the block with its defaults: `WIDTH = 16` and `SETTLE_CYC = 2`. Each conversion therefore takes 18 cycles, which leaves room to toggle the controls in mid-conversion and to raise power-down partway through the trial phase. With full 16-bit width, the bench can reach the all-zeros and all-ones codes and the codes on either side of mid-scale, which exercise every keep and clear decision. The two settle cycles place the latch edge apart from the last trial edge, so the busy-length and result-timing checks can tell the two edges apart.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_TRIAL  = 2'd1,
    PH_SETTLE = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rdconv_n,
  input  logic pwr_down,
  output logic start_o
);
  logic merged;
  logic merged_q;

  // Merged control is low only when both controls are low.
  assign merged = cs_n | rdconv_n;

  // Reset as "high" so controls already low at reset start nothing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) merged_q <= 1'b1;
    else        merged_q <= merged;
  end

  assign start_o = merged_q & ~merged & ~pwr_down;
endmodule

// File: rtl/sar_trial_engine.sv
module sar_trial_engine
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cmp_le,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] trial_o
);
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
  localparam logic [WIDTH-1:0] MSB_ONLY = ONE << (WIDTH - 1);
  localparam logic [CNT_W-1:0] LAST_SET = CNT_W'(SETTLE_CYC - 1);

  sar_phase_e        phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  settle_q;
  logic [WIDTH-1:0]  trial_q;
  logic [WIDTH-1:0]  mask;
  logic [WIDTH-1:0]  kept;
  logic [WIDTH-1:0]  trial_nxt;

  // Bit decision: keep the bit under test if DAC <= input, then set the next one.
  always_comb begin
    mask      = ONE << idx_q;
    kept      = cmp_le ? trial_q : (trial_q & ~mask);
    trial_nxt = (idx_q != '0) ? (kept | (mask >> 1)) : kept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      settle_q <= '0;
      trial_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_TRIAL;
            trial_q <= MSB_ONLY;
            idx_q   <= IDX_W'(WIDTH - 1);
          end
        end
        PH_TRIAL: begin
          if (abort_i) begin
            phase_q <= PH_IDLE;
            trial_q <= '0;
          end else begin
            trial_q <= trial_nxt;
            if (idx_q == '0) begin
              phase_q  <= PH_SETTLE;
              settle_q <= '0;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
        end
        PH_SETTLE: begin
          if (abort_i || settle_q == LAST_SET) begin
            phase_q <= PH_IDLE;
            trial_q <= '0;
          end else begin
            settle_q <= settle_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          trial_q <= '0;
        end
      endcase
    end
  end

  assign busy_o  = (phase_q == PH_IDLE);
  assign done_o  = (phase_q == PH_SETTLE) && (settle_q == LAST_SET) && !abort_i;
  assign trial_o = trial_q;
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ok_o
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      ok_o     <= 1'b0;
      seen_q   <= 1'b0;
    end else if (load_i) begin
      result_o <= code_i;
      ok_o     <= seen_q;   // first completed conversion is marked not valid
      seen_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_start_seq.sv
module sar_start_seq #(
  parameter int WIDTH      = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rdconv_n,
  input  logic             pwr_down,
  input  logic             cmp_le,
  output logic             busy,
  output logic [WIDTH-1:0] dac_trial,
  output logic [WIDTH-1:0] result,
  output logic             result_ok
);
  logic start_req;
  logic done;

  sar_start_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rdconv_n (rdconv_n),
    .pwr_down (pwr_down),
    .start_o  (start_req)
  );

  sar_trial_engine #(
    .WIDTH      (WIDTH),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_req),
    .abort_i (pwr_down),
    .cmp_le  (cmp_le),
    .busy_o  (busy),
    .done_o  (done),
    .trial_o (dac_trial)
  );

  sar_result_reg #(
    .WIDTH (WIDTH)
  ) u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (done),
    .code_i   (dac_trial),
    .result_o (result),
    .ok_o     (result_ok)
  );
endmodule

// File: rtl/sar_start_seq_chk.sv
module sar_start_seq_chk #(
  parameter int WIDTH      = 16,
  parameter int SETTLE_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rdconv_n,
  input logic             pwr_down,
  input logic             busy,
  input logic [WIDTH-1:0] dac_trial,
  input logic [WIDTH-1:0] result
);
  localparam int LCW = $clog2(WIDTH + SETTLE_CYC + 2);
  localparam logic [LCW-1:0] CONV_LEN = LCW'(WIDTH + SETTLE_CYC);
  localparam logic [WIDTH-1:0] MSB_ONLY = WIDTH'(1) << (WIDTH - 1);

  logic [LCW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= '0;
    else if (!busy) low_cnt <= low_cnt + 1'b1;
    else            low_cnt <= '0;
  end

  a_r1_start_needs_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!$past(cs_n) && !$past(rdconv_n) && !$past(pwr_down)));

  a_r2_busy_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(pwr_down)) |-> (low_cnt == CONV_LEN));

  a_r3_result_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(busy));

  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (dac_trial == MSB_ONLY));

  a_r6_pwrdn_holds_result: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_down) |-> $stable(result));

  a_r9_dac_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dac_trial == '0));
endmodule

bind sar_start_seq sar_start_seq_chk #(
  .WIDTH      (WIDTH),
  .SETTLE_CYC (SETTLE_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rdconv_n  (rdconv_n),
  .pwr_down  (pwr_down),
  .busy      (busy),
  .dac_trial (dac_trial),
  .result    (result)
);

// File: tb/sar_start_seq_tb.sv
module sar_start_seq_tb_top;
  localparam int W   = 16;
  localparam int SET = 2;
  localparam int CONV_LEN = W + SET;
  localparam int NVEC = 6;
  // {mode[1:0], target[15:0]}; mode 0: cs_n falls last, 1: rdconv_n falls last, 2: both together
  localparam logic [17:0] VECS [NVEC] = '{
    {2'd0, 16'hA5C3},
    {2'd1, 16'h0000},
    {2'd2, 16'hFFFF},
    {2'd0, 16'h8000},
    {2'd1, 16'h7FFF},
    {2'd2, 16'h0001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rdconv_n = 1'b1;
  logic pwr_down = 1'b0;
  logic [W-1:0] target = '0;
  logic cmp_le;
  logic busy;
  logic [W-1:0] dac_trial;
  logic [W-1:0] result;
  logic result_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // Behavioural comparator: DAC level at or below the held input.
  assign cmp_le = (dac_trial <= target);

  sar_start_seq #(.WIDTH(W), .SETTLE_CYC(SET)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdconv_n(rdconv_n),
    .pwr_down(pwr_down), .cmp_le(cmp_le), .busy(busy),
    .dac_trial(dac_trial), .result(result), .result_ok(result_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_ctrl();
    @(negedge clk);
    cs_n = 1'b1; rdconv_n = 1'b1;
    @(negedge clk);
  endtask

  // Drive a start in the given order; returns at the negedge after the start edge.
  task automatic do_start(input logic [1:0] mode);
    if (mode == 2'd0) begin
      rdconv_n = 1'b0; @(negedge clk); cs_n = 1'b0;
    end else if (mode == 2'd1) begin
      cs_n = 1'b0; @(negedge clk); rdconv_n = 1'b0;
    end else begin
      cs_n = 1'b0; rdconv_n = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic count_low(output int n, input bit poke);
    n = 0;
    while (busy == 1'b0 && n < 100) begin
      n++;
      if (poke && n == 4) rdconv_n = 1'b1;
      if (poke && n == 5) rdconv_n = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    logic [W-1:0] last;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 busy", 32'(busy), 32'd1);
    chk("R8 result", 32'(result), 32'd0);
    chk("R8 result_ok", 32'(result_ok), 32'd0);
    chk("R8 dac_trial", 32'(dac_trial), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 abandon in mid-conversion, before any completion
    target = 16'h1234;
    do_start(2'd1);
    chk("R2 busy low after start", 32'(busy), 32'd0);
    repeat (5) @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    chk("R6 abort busy high", 32'(busy), 32'd1);
    chk("R6 abort result kept", 32'(result), 32'd0);
    chk("R9 dac zero after abort", 32'(dac_trial), 32'd0);
    @(negedge clk);
    pwr_down = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 start not remembered", 32'(busy), 32'd1);
    idle_ctrl();

    // Vector walk: R1 orders, R2 length, R4 code, R7 validity
    for (int i = 0; i < NVEC; i++) begin
      target = VECS[i][15:0];
      do_start(VECS[i][17:16]);
      chk("R4 first trial msb", 32'(dac_trial), 32'h8000);
      count_low(n, 1'b0);
      chk("R2 busy low cycles", 32'(n), 32'(CONV_LEN));
      chk("R4 result code", 32'(result), 32'(VECS[i][15:0]));
      chk("R7 result_ok", 32'(result_ok), (i == 0) ? 32'd0 : 32'd1);
      chk("R9 dac zero idle", 32'(dac_trial), 32'd0);
      // R1: holding both low starts nothing
      repeat (4) @(negedge clk);
      chk("R1 no restart while held low", 32'(busy), 32'd1);
      idle_ctrl();
    end

    // R5: start during busy ignored, not queued
    target = 16'h3C5A;
    do_start(2'd1);
    count_low(n, 1'b1);
    chk("R5 busy length unchanged", 32'(n), 32'(CONV_LEN));
    chk("R5 result", 32'(result), 32'h3C5A);
    repeat (3) @(negedge clk);
    chk("R5 no queued start", 32'(busy), 32'd1);
    idle_ctrl();

    // R6: start ignored during power-down, result held
    last = result;
    target = 16'hFFFF;
    pwr_down = 1'b1;
    @(negedge clk);
    do_start(2'd0);
    repeat (4) @(negedge clk);
    chk("R6 start ignored", 32'(busy), 32'd1);
    chk("R6 result held", 32'(result), 32'(last));
    pwr_down = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 no start after release", 32'(busy), 32'd1);
    idle_ctrl();

    // R3: result unchanged in mid-conversion
    target = 16'h0F0F;
    do_start(2'd2);
    repeat (10) @(negedge clk);
    chk("R3 result stable mid-conversion", 32'(result), 32'(last));
    count_low(n, 1'b0);
    chk("R3 result after busy rise", 32'(result), 32'h0F0F);
    idle_ctrl();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule